// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

The block receives asynchronous serial frames on a single line and places each byte in a holding register. It samples the line at sixteen times the bit rate, taken from a one-cycle enable pulse supplied by an external divider. A frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A four-bit status word reports when the holding register is full, and carries three error flags: overrun, parity and framing.

Software controls the block through three paths. A status read arms a clear for each flag that reads as 1. A later status write with 0 in a flag's position then clears that flag. A separate read strobe, of the kind a DMA engine drives when it answers the interrupt request, empties the holding register directly. The error flags are sticky. While any of them is set, the receiver ignores new frames, so software must handle every error before reception continues. The synchronised line level is also brought out, so that software can tell a break condition apart from a single bad frame.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, `status` is 0, `rx_data` is 0 and `rx_irq` is 0.
- R2: A frame that starts on a falling edge of `rxd` is decoded as follows. One bit lasts 16 `tick` pulses. Each bit is decided by a majority vote of the samples taken at ticks 7, 8 and 9 of that bit. The eight data bits arrive least significant bit first. When a valid frame completes, its byte is written to `rx_data` and the full flag, `status[3]`, is set.
- R3: A start bit is confirmed only if the vote at mid-bit reads 0. A low pulse shorter than half a bit time therefore loads nothing and sets no flag.
- R4: When `par_en` is 1, a parity bit follows the data bits. The parity is even when `par_odd` is 0 and odd when `par_odd` is 1. A parity mismatch sets the parity flag, `status[1]`, and leaves `rx_data` and the full flag unchanged.
- R5: A stop bit sampled as 0 sets the framing flag, `status[0]`, and no byte is loaded. The framing check has priority over the parity and overrun checks. `rxd_level` follows `rxd` through a two-flop synchroniser, so a line that stays low can be observed as a break.
- R6: The overrun check applies when a frame's stop bit is sampled and the frame has neither a framing nor a parity error. If the full flag is still 1 at that moment, the overrun flag, `status[2]`, is set, the new byte is discarded and `rx_data` keeps the earlier byte.
- R7: While any of `status[2:0]` is 1, no new frame is accepted. Reception resumes once all three flags are 0.
- R8: A status write with `stat_wdata` bit i = 0 clears flag i only if a status read after the most recent status write saw flag i as 1. Writing 1 to a flag has no effect. A flag that is set after the status read survives the write.
- R9: A pulse on `dma_rd` clears the full flag on the next clock edge.
- R10: `rx_irq` is 1 exactly while the full flag is 1.
- R11: While `rx_en` is 0, a frame in progress is abandoned and no new frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | 1 = a parity bit is present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial line, idles high |
| stat_rd | input | 1 | Status read strobe; arms a clear for each flag that reads as 1 |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 4 | Write data; 0 in a position clears that flag if it is armed |
| dma_rd | input | 1 | DMA read strobe; clears the full flag |
| rx_data | output | 8 | Last byte accepted |
| status | output | 4 | {full, overrun, parity, framing} |
| rx_irq | output | 1 | Receive interrupt request |
| rxd_level | output | 1 | Synchronised line level |

## Verification
The hardest case to reach is a flag that is set between the status read and the status write that follows it. The bench reads the status while the register is empty and then sends a whole frame. It writes zero to the full flag only after the frame has landed, and checks that the flag is still set. Overrun is reached by sending two frames with no drain in between. A third frame is then sent while the overrun flag is pending, to confirm that the receiver stays frozen. For the abandoned frame, `rx_en` is dropped partway through a byte that is chosen so that no falling edge follows the point where `rx_en` is restored.

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [3:0]        stat_wdata,
  input  logic              dma_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic [3:0]        status,
  output logic              rx_irq,
  output logic              rxd_level
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] C_A   = CW'(MID - 1);
  localparam logic [CW-1:0] C_B   = CW'(MID);
  localparam logic [CW-1:0] C_V   = CW'(MID + 1);
  localparam logic [CW-1:0] C_END = CW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t               st;
  logic [1:0]        sync;
  logic              rx_prev;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              s_a, s_b, par_acc, par_bad;
  logic              full, ovr, per, fer;
  logic [3:0]        arm;

  wire rx_s    = sync[1];
  wire err_any = ovr | per | fer;
  wire fall    = rx_prev & ~rx_s;
  wire at_vote = tick && (cnt == C_V);
  wire at_end  = tick && (cnt == C_END);
  wire vote    = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  wire done    = rx_en && (st == S_STOP) && at_vote;
  wire bad_par = par_en & par_bad;
  wire fer_set = done & ~vote;
  wire per_set = done & vote & bad_par;
  wire ovr_set = done & vote & ~bad_par & full;
  wire load    = done & vote & ~bad_par & ~full;
  wire [3:0] clr = {4{stat_wr}} & ~stat_wdata & arm;

  assign status    = {full, ovr, per, fer};
  assign rx_irq    = full;
  assign rxd_level = rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync    <= {sync[0], rxd};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      par_acc <= 1'b0;
      par_bad <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else begin
      if (st != S_IDLE && tick) begin
        cnt <= (cnt == C_END) ? '0 : cnt + 1'b1;
        if (cnt == C_A) s_a <= rx_s;
        if (cnt == C_B) s_b <= rx_s;
      end
      case (st)
        S_IDLE: if (fall && !err_any) begin
          st      <= S_START;
          cnt     <= '0;
          par_acc <= 1'b0;
          par_bad <= 1'b0;
        end
        S_START: begin
          if (at_vote && vote) st <= S_IDLE;
          else if (at_end) begin
            st   <= S_DATA;
            bitn <= '0;
          end
        end
        S_DATA: begin
          if (at_vote) begin
            shreg   <= {vote, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ vote;
          end
          if (at_end) begin
            bitn <= bitn + 1'b1;
            if (bitn == B_LAST) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          if (at_vote) par_bad <= par_acc ^ vote ^ par_odd;
          if (at_end) st <= S_STOP;
        end
        S_STOP: if (at_vote) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      full    <= 1'b0;
      ovr     <= 1'b0;
      per     <= 1'b0;
      fer     <= 1'b0;
      arm     <= '0;
    end else begin
      if (load) begin
        rx_data <= shreg;
        full    <= 1'b1;
      end else if (dma_rd || clr[3]) full <= 1'b0;
      if (ovr_set) ovr <= 1'b1; else if (clr[2]) ovr <= 1'b0;
      if (per_set) per <= 1'b1; else if (clr[1]) per <= 1'b0;
      if (fer_set) fer <= 1'b1; else if (clr[0]) fer <= 1'b0;
      if (stat_wr)      arm <= '0;
      else if (stat_rd) arm <= (arm & status) | status;
      else              arm <= arm & status;
    end
  end
endmodule

module uart_rx_sticky_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              stat_wr,
  input logic              dma_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic [3:0]        status
);
  AST_DMA_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) dma_rd |=> !status[3]); // R9
  AST_NO_LOAD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) (|status[2:0]) |=> $stable(rx_data)); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) status[3] |=> $stable(rx_data)); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> !$rose(status[3])); // R11
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status[2] && !stat_wr) |=> status[2]); // R8
  AST_PER_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status[1] && !stat_wr) |=> status[1]); // R8
  AST_FER_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status[0] && !stat_wr) |=> status[0]); // R5
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .stat_wr(stat_wr),
  .dma_rd(dma_rd), .rx_data(rx_data), .status(status)
);

// File: tb/uart_rx_sticky_test.sv
module uart_rx_sticky_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, rxd = 1'b1;
  logic stat_rd = 1'b0, stat_wr = 1'b0, dma_rd = 1'b0;
  logic [3:0] stat_wdata = 4'hF;
  logic [7:0] rx_data;
  logic [3:0] status;
  logic rx_irq, rxd_level;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [9:0] expq[$];
  logic [3:0] prev_st = 4'h0;

  localparam logic [1:0] K_DATA = 2'd0, K_FER = 2'd1, K_PER = 2'd2, K_OVR = 2'd3;

  always #5 clk = ~clk;

  uart_rx_sticky uut (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .rx_en(rx_en), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .dma_rd(dma_rd), .rx_data(rx_data),
    .status(status), .rx_irq(rx_irq), .rxd_level(rxd_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [7:0] d);
    expq.push_back({k, d});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input logic stop);
    logic p;
    p = ^d ^ par_odd ^ bad_par;
    rxd = 1'b0; idle(16);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(16); end
    if (par_en) begin rxd = p; idle(16); end
    rxd = stop; idle(16);
    idle(24);
  endtask

  task automatic drain();
    dma_rd = 1'b1; @(negedge clk); dma_rd = 1'b0;
  endtask

  task automatic rd_wr(input logic [3:0] w, input bit do_rd);
    if (do_rd) begin stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; end
    stat_wr = 1'b1; stat_wdata = w; @(negedge clk); stat_wr = 1'b0; stat_wdata = 4'hF;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < 4; b++) begin
        if (status[b] && !prev_st[b]) begin
          logic [1:0] k;
          logic [9:0] e;
          k = (b == 3) ? K_DATA : (b == 2) ? K_OVR : (b == 1) ? K_PER : K_FER;
          if (expq.size() == 0) check("R2 unexpected event", {30'd0, k}, 32'hFF);
          else begin
            e = expq.pop_front();
            check("R2/R4/R5/R6 event kind", {30'd0, k}, {30'd0, e[9:8]});
            if (k == K_DATA) check("R2 byte", {24'd0, rx_data}, {24'd0, e[7:0]});
          end
        end
      end
      prev_st = status;
    end
  end

  initial begin
    for (;;) begin
      @(posedge clk); cyc++;
      if (cyc == 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    check("R1 status", {28'd0, status}, 0);
    check("R1 data", {24'd0, rx_data}, 0);
    check("R1 irq", {31'd0, rx_irq}, 0);
    rst_n = 1'b1; rx_en = 1'b1; idle(4);

    expect_ev(K_DATA, 8'hA5); send(8'hA5, 0, 1);
    check("R2 status full", {28'd0, status}, 4'b1000);
    check("R10 irq high", {31'd0, rx_irq}, 1);
    drain();
    check("R9 dma clears full", {28'd0, status}, 0);
    check("R10 irq low", {31'd0, rx_irq}, 0);

    expect_ev(K_DATA, 8'h3C); send(8'h3C, 0, 1);
    rd_wr(4'b0000, 0);
    check("R8 write without read", {31'd0, status[3]}, 1);
    rd_wr(4'b1111, 1);
    check("R8 write of one", {31'd0, status[3]}, 1);
    rd_wr(4'b0111, 1);
    check("R8 read then write zero", {28'd0, status}, 0);

    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    expect_ev(K_DATA, 8'h5A); send(8'h5A, 0, 1);
    rd_wr(4'b0111, 0);
    check("R8 late set survives", {31'd0, status[3]}, 1);
    drain();

    expect_ev(K_DATA, 8'h11); send(8'h11, 0, 1);
    expect_ev(K_OVR, 8'h00); send(8'h22, 0, 1);
    check("R6 status", {28'd0, status}, 4'b1100);
    check("R6 byte kept", {24'd0, rx_data}, 8'h11);
    drain();
    send(8'h33, 0, 1);
    check("R7 frozen full", {28'd0, status}, 4'b0100);
    check("R7 frozen data", {24'd0, rx_data}, 8'h11);
    rd_wr(4'b1011, 1);
    check("R7 ovr cleared", {28'd0, status}, 0);
    expect_ev(K_DATA, 8'h44); send(8'h44, 0, 1);
    check("R7 resumed", {24'd0, rx_data}, 8'h44);
    drain();

    par_en = 1'b1; par_odd = 1'b0;
    expect_ev(K_DATA, 8'h81); send(8'h81, 0, 1);
    drain();
    expect_ev(K_PER, 8'h00); send(8'h07, 1, 1);
    check("R4 parity flag only", {28'd0, status}, 4'b0010);
    check("R4 data kept", {24'd0, rx_data}, 8'h81);
    rd_wr(4'b1101, 1);
    par_odd = 1'b1;
    expect_ev(K_DATA, 8'h07); send(8'h07, 0, 1);
    check("R4 odd parity accepted", {24'd0, rx_data}, 8'h07);
    drain();
    par_en = 1'b0;

    expect_ev(K_FER, 8'h00); send(8'h00, 0, 0);
    check("R5 framing flag", {28'd0, status}, 4'b0001);
    check("R5 break level", {31'd0, rxd_level}, 0);
    rxd = 1'b1; idle(4);
    check("R5 line released", {31'd0, rxd_level}, 1);
    rd_wr(4'b1110, 1);
    check("R5 fer cleared", {28'd0, status}, 0);

    rxd = 1'b0; idle(4); rxd = 1'b1; idle(200);
    check("R3 glitch ignored", {28'd0, status}, 0);
    expect_ev(K_DATA, 8'h96); send(8'h96, 0, 1);
    drain();

    rx_en = 1'b0; send(8'hF0, 0, 1);
    check("R11 disabled", {28'd0, status}, 0);
    rx_en = 1'b1; idle(4);
    fork
      send(8'h0F, 0, 1);
      begin idle(60); rx_en = 1'b0; idle(30); rx_en = 1'b1; end
    join
    check("R11 aborted frame", {28'd0, status}, 0);
    expect_ev(K_DATA, 8'hC3); send(8'hC3, 0, 1);
    drain();

    check("R2 all events seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule